// File: doc/BRIEF.md
# Host Receive Endpoint Packet Tracker with Automatic Re-request

This block keeps the software-visible status of a host-mode receive (IN) endpoint whose buffer holds either one packet or, with double buffering enabled, two. It counts the packets that the link side reports as received and not yet taken by software. It shows a ready flag while any packet is waiting, flags an overrun when a packet arrives with no free slot, and holds the request bit that asks the transaction engine to issue the next IN transaction.

Software controls the block through a small register port with two registers: a control/status register and a FIFO size register. Software frees a slot by writing 0 to the ready bit. When automatic re-request is enabled and the endpoint is serviced by the CPU rather than by DMA, freeing a slot also sets the request bit, so the next IN transaction needs no second register write. The request bit clears when the link reports that an IN transaction has started.

Top module: `hrx_autoreq`

## Requirements
- R1: After reset the control/status register reads 0x00 and the FIFO size register reads 0x00. The request output is low.
- R2: Control/status bit 0 (ready) reads 1 in the cycle after a packet-received strobe, and stays 1 while at least one packet is held.
- R3: With FIFO size bit 4 at 0 the capacity is one packet. A packet that arrives while the buffer is full, with no slot freed in that cycle, sets control/status bit 2 (overrun) and is dropped, so the held count does not change.
- R4: With FIFO size bit 4 at 1 the capacity is two packets. Writing 0 to ready while two are held leaves ready reading 1 in the next cycle. A second such write makes it read 0. Bit 4 reads back as written.
- R5: A register write with bit 5 at 1 sets the request bit (control/status bit 5, also driven on `req_pkt`) in the next cycle. When the buffer is full the write is ignored.
- R6: When bit 7 (auto-request enable) is 1 and bit 6 (DMA service) is 0, a write of 0 to ready while ready is 1 sets the request bit in the next cycle.
- R7: When bit 6 is 1, freeing a slot does not set the request bit.
- R8: An `in_start` pulse clears the request bit in the next cycle. A set in the same cycle takes priority over the clear.
- R9: Writing 0 to bit 2 clears overrun. Writing 1 to bit 0 or bit 2 has no effect, and writing 0 to bit 5 has no effect.
- R10: Writing 0 to ready while no packet is held changes nothing, and it does not trigger an automatic request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control/status, 1 = FIFO size |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pkt_rcvd | input | 1 | One-cycle pulse: a packet was received into the buffer |
| in_start | input | 1 | One-cycle pulse: an IN transaction has started |
| req_pkt | output | 1 | Request for the next IN transaction |

## Verification
The assertions assume that `pkt_rcvd` and `in_start` are single-cycle pulses, that a register write lasts one cycle, and that software writes 1 to the bits it wants to keep, because the bits that software clears act on a written 0. The stimulus drives every strobe for exactly one clock and sets each register write value so that only the intended bit carries a 0. It also reaches the full buffer in both capacities, so that the overrun and blocked-request properties are exercised at their boundary.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

   // Register-write intents decoded from one bus write
   typedef struct packed {
      logic pop_try;   // software wrote 0 to ready
      logic ovr_clr;   // software wrote 0 to overrun
      logic req_set;   // software wrote 1 to request
      logic cfg_we;    // control/status write: update config bits
      logic auto_val;  // new auto-request enable
      logic dma_val;   // new DMA-service flag
      logic fsz_we;    // FIFO size register write
      logic dpb_val;   // new double-buffer enable
   } hrx_wr_t;

endpackage

// File: rtl/hrx_wr_decode.sv
module hrx_wr_decode
   import hrx_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int RDY_BIT  = 0,
   parameter int OVR_BIT  = 2,
   parameter int REQ_BIT  = 5,
   parameter int DMA_BIT  = 6,
   parameter int AUTO_BIT = 7,
   parameter int DPB_BIT  = 4
) (
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] wdata,
   output hrx_wr_t          wr
);

   logic ctl_we;
   logic fsz_we;

   assign ctl_we = reg_wr & ~reg_sel;
   assign fsz_we = reg_wr &  reg_sel;

   always_comb begin
      wr          = '0;
      wr.pop_try  = ctl_we & ~wdata[RDY_BIT];
      wr.ovr_clr  = ctl_we & ~wdata[OVR_BIT];
      wr.req_set  = ctl_we &  wdata[REQ_BIT];
      wr.cfg_we   = ctl_we;
      wr.auto_val = wdata[AUTO_BIT];
      wr.dma_val  = wdata[DMA_BIT];
      wr.fsz_we   = fsz_we;
      wr.dpb_val  = wdata[DPB_BIT];
   end

endmodule

// File: rtl/hrx_slot_track.sv
module hrx_slot_track #(
   parameter int MAX_HELD = 2,
   parameter bit HAS_DPB  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_rcvd,
   input  logic pop_try,
   input  logic ovr_clr,
   input  logic dpb_en,
   output logic rdy,
   output logic full,
   output logic pop,
   output logic ovr
);

   localparam int CNT_W = $clog2(MAX_HELD + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap;
   logic             accept;

   generate
      if (HAS_DPB) begin : g_dual
         assign cap = dpb_en ? CNT_W'(MAX_HELD) : CNT_W'(1);
      end else begin : g_single
         logic dpb_unused;
         assign dpb_unused = dpb_en;
         assign cap = CNT_W'(1);
      end
   endgenerate

   assign rdy    = (cnt_q != '0);
   assign full   = (cnt_q >= cap);
   assign pop    = pop_try & rdy;
   assign accept = pkt_rcvd & (~full | pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovr   <= 1'b0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(pop);
         if (pkt_rcvd && !accept)
            ovr <= 1'b1;
         else if (ovr_clr)
            ovr <= 1'b0;
      end
   end

   // R4: count never exceeds the largest capacity
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_HELD));

   // R3: arrival into a full buffer with no slot freed flags overrun
   p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_rcvd && full && !pop) |=> ovr);

   // R3: a dropped packet leaves the count unchanged
   p_drop_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_rcvd && full && !pop) |=> $stable(cnt_q));

   // R4: freeing one of two held packets keeps ready asserted
   p_second_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt_q > CNT_W'(1)) |=> rdy);

   // R10: a clear attempt on an empty buffer frees nothing
   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try && !rdy && !pkt_rcvd) |=> !rdy);

endmodule

// File: rtl/hrx_req_ctrl.sv
module hrx_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_set,
   input  logic full,
   input  logic pop,
   input  logic auto_en,
   input  logic dma_mode,
   input  logic in_start,
   output logic req
);

   logic sw_ok;
   logic auto_set;

   assign sw_ok    = sw_set & ~full;
   assign auto_set = pop & auto_en & ~dma_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req <= 1'b0;
      else if (sw_ok || auto_set)
         req <= 1'b1;
      else if (in_start)
         req <= 1'b0;
   end

   // R6: CPU-serviced auto-request re-arms on a freed slot
   p_auto_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && auto_en && !dma_mode) |=> req);

   // R7: in DMA service a freed slot alone does not raise the request
   p_dma_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && dma_mode && !sw_set && !req) |=> !req);

   // R5: a software request is refused while the buffer is full
   p_full_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_set && full && !pop && !req) |=> !req);

   // R8: transaction start drops the request unless re-set
   p_in_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_start && !sw_set && !pop) |=> !req);

endmodule

// File: rtl/hrx_autoreq.sv
module hrx_autoreq
   import hrx_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int MAX_HELD = 2,
   parameter bit HAS_DPB  = 1'b1,
   parameter int RDY_BIT  = 0,
   parameter int OVR_BIT  = 2,
   parameter int REQ_BIT  = 5,
   parameter int DMA_BIT  = 6,
   parameter int AUTO_BIT = 7,
   parameter int DPB_BIT  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             pkt_rcvd,
   input  logic             in_start,
   output logic             req_pkt
);

   localparam int CTL_BITS = 5;

   generate
      if (RDY_BIT >= REG_W || OVR_BIT >= REG_W || REQ_BIT >= REG_W ||
          DMA_BIT >= REG_W || AUTO_BIT >= REG_W || DPB_BIT >= REG_W) begin : g_bad_pos
         $error("hrx_autoreq: bit position outside register width");
      end
      if (REG_W < CTL_BITS) begin : g_bad_width
         $error("hrx_autoreq: register too narrow for control fields");
      end
      if (MAX_HELD < 1) begin : g_bad_depth
         $error("hrx_autoreq: MAX_HELD must be at least 1");
      end
      if (RDY_BIT == OVR_BIT || RDY_BIT == REQ_BIT || RDY_BIT == DMA_BIT ||
          RDY_BIT == AUTO_BIT || OVR_BIT == REQ_BIT || OVR_BIT == DMA_BIT ||
          OVR_BIT == AUTO_BIT || REQ_BIT == DMA_BIT || REQ_BIT == AUTO_BIT ||
          DMA_BIT == AUTO_BIT) begin : g_bad_overlap
         $error("hrx_autoreq: control field positions overlap");
      end
   endgenerate

   hrx_wr_t wr;
   logic    rdy, full, pop, ovr;
   logic    auto_en_q, dma_q, dpb_q;

   hrx_wr_decode #(
      .REG_W(REG_W), .RDY_BIT(RDY_BIT), .OVR_BIT(OVR_BIT), .REQ_BIT(REQ_BIT),
      .DMA_BIT(DMA_BIT), .AUTO_BIT(AUTO_BIT), .DPB_BIT(DPB_BIT)
   ) u_dec (
      .reg_wr  (reg_wr),
      .reg_sel (reg_sel),
      .wdata   (reg_wdata),
      .wr      (wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_en_q <= 1'b0;
         dma_q     <= 1'b0;
      end else if (wr.cfg_we) begin
         auto_en_q <= wr.auto_val;
         dma_q     <= wr.dma_val;
      end
   end

   generate
      if (HAS_DPB) begin : g_dpb_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dpb_q <= 1'b0;
            else if (wr.fsz_we)
               dpb_q <= wr.dpb_val;
         end
      end else begin : g_dpb_none
         logic dpb_unused;
         assign dpb_unused = wr.fsz_we ^ wr.dpb_val;
         assign dpb_q = 1'b0;
      end
   endgenerate

   hrx_slot_track #(
      .MAX_HELD (MAX_HELD),
      .HAS_DPB  (HAS_DPB)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_rcvd (pkt_rcvd),
      .pop_try  (wr.pop_try),
      .ovr_clr  (wr.ovr_clr),
      .dpb_en   (dpb_q),
      .rdy      (rdy),
      .full     (full),
      .pop      (pop),
      .ovr      (ovr)
   );

   hrx_req_ctrl u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   (wr.req_set),
      .full     (full),
      .pop      (pop),
      .auto_en  (auto_en_q),
      .dma_mode (dma_q),
      .in_start (in_start),
      .req      (req_pkt)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata[DPB_BIT] = dpb_q;
      end else begin
         reg_rdata[RDY_BIT]  = rdy;
         reg_rdata[OVR_BIT]  = ovr;
         reg_rdata[REQ_BIT]  = req_pkt;
         reg_rdata[DMA_BIT]  = dma_q;
         reg_rdata[AUTO_BIT] = auto_en_q;
      end
   end

   // R9: overrun clears only through a written 0
   p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !wr.ovr_clr) |=> ovr);

   // R2: a stored packet shows as ready
   p_rdy_after_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_rcvd && !full) |=> reg_rdata[RDY_BIT] || reg_sel);

endmodule

// File: tb/tb_hrx_autoreq.sv
module tb_hrx_autoreq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       reg_wr, reg_sel, pkt_rcvd, in_start;
   logic [7:0] reg_wdata, reg_rdata;
   logic       req_pkt;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   hrx_autoreq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_rcvd(pkt_rcvd),
      .in_start(in_start), .req_pkt(req_pkt)
   );

   // ops: 0 idle, 1 packet, 2 IN start, 3 write ctl, 4 write fifo size
   // {op[3:0], wdata[7:0], expected ctl[7:0], req tag[3:0]}
   localparam int NV = 23;
   localparam logic [23:0] VEC [NV] = '{
      {4'd0, 8'h00, 8'h00, 4'd1},   // R1 idle after reset
      {4'd1, 8'h00, 8'h01, 4'd2},   // R2 packet -> ready
      {4'd3, 8'h25, 8'h01, 4'd5},   // R5 request refused, full
      {4'd1, 8'h00, 8'h05, 4'd3},   // R3 overrun, single
      {4'd3, 8'h01, 8'h01, 4'd9},   // R9 clear overrun
      {4'd3, 8'h04, 8'h00, 4'd3},   // R3 dropped packet gone
      {4'd3, 8'h04, 8'h00, 4'd10},  // R10 clear on empty
      {4'd3, 8'h25, 8'h20, 4'd5},   // R5 software request
      {4'd2, 8'h00, 8'h00, 4'd8},   // R8 IN start clears
      {4'd4, 8'h10, 8'h00, 4'd4},   // R4 enable double buffer
      {4'd1, 8'h00, 8'h01, 4'd2},   // R2 first packet
      {4'd1, 8'h00, 8'h01, 4'd4},   // R4 second packet held
      {4'd3, 8'h85, 8'h81, 4'd6},   // R6 auto enable
      {4'd3, 8'h84, 8'hA1, 4'd6},   // R6 auto request, R4 still ready
      {4'd2, 8'h00, 8'h81, 4'd8},   // R8
      {4'd1, 8'h00, 8'h81, 4'd4},   // R4 two held again
      {4'd1, 8'h00, 8'h85, 4'd3},   // R3 overrun in double mode
      {4'd3, 8'hC1, 8'hC1, 4'd9},   // R9 DMA on, overrun cleared
      {4'd3, 8'hC4, 8'hC1, 4'd7},   // R7 no auto request in DMA
      {4'd3, 8'hC4, 8'hC0, 4'd7},   // R7 empty, still no request
      {4'd3, 8'hE5, 8'hE0, 4'd5},   // R5 request while not full
      {4'd3, 8'h05, 8'h20, 4'd9},   // R9 writing 0 to bit 5 keeps it
      {4'd2, 8'h00, 8'h00, 4'd8}    // R8
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int rq);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d: got %02h expected %02h", rq, act, exp);
      end
   endtask

   task automatic step(input int op, input logic [7:0] wd);
      reg_wdata = wd;
      reg_wr    = (op == 3 || op == 4);
      reg_sel   = (op == 4);
      pkt_rcvd  = (op == 1);
      in_start  = (op == 2);
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_sel = 1'b0; pkt_rcvd = 1'b0; in_start = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #500000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
      pkt_rcvd = 1'b0; in_start = 1'b0;
      repeat (3) @(negedge clk);
      check({7'd0, req_pkt}, 8'h00, 1);          // R1 request low
      reg_sel = 1'b1; #1;
      check(reg_rdata, 8'h00, 1);                // R1 fifo size reset
      reg_sel = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(int'(VEC[i][23:20]), VEC[i][19:12]);
         check(reg_rdata, VEC[i][11:4], int'(VEC[i][3:0]));
      end

      // R4 fifo size bit reads back
      reg_sel = 1'b1; #1;
      check(reg_rdata, 8'h10, 4);
      reg_sel = 1'b0;

      // R8 set and IN start in the same cycle: set wins
      reg_wdata = 8'h25; reg_wr = 1'b1; in_start = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; in_start = 1'b0;
      @(negedge clk);
      check({7'd0, req_pkt}, 8'h01, 8);
      step(2, 8'h00);
      check({7'd0, req_pkt}, 8'h00, 8);

      // R3 single buffer: clear and arrival together is not an overrun
      step(4, 8'h00);
      step(1, 8'h00);
      reg_wdata = 8'h04; reg_wr = 1'b1; pkt_rcvd = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; pkt_rcvd = 1'b0;
      @(negedge clk);
      check(reg_rdata, 8'h01, 3);

      // R1 reset in mid-run returns to idle
      rst_n = 1'b0;
      @(negedge clk);
      check(reg_rdata, 8'h00, 1);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule